// File: doc/BRIEF.md
# External DMA Request Arbiter Interface

This block sits between an active-low DMA request pin, driven by a device outside the chip, and the channel arbitration of a multi-channel DMA controller. The pin is brought into the controller clock domain through a short flip-flop chain. The synchronized level then serves as the request of the one channel that is configured to take its request from the pin. Every other channel takes its request from an internal request line.

When idle, the arbiter picks one pending channel per burst and holds it until the burst engine signals completion. When the winning channel is the externally sourced one, an active-low grant pin stays low for the whole burst. While that grant is low, the synchronizer is frozen and the pin is ignored. A single assertion of the pin produces exactly one burst. After an external burst, the external channel yields to any competing request on its next turn.

Top module: `ext_dma_req_arb`

## Requirements
- R1: After reset the grant output is high (inactive), `burst_active` is 0, and the synchronizer holds an inactive request.
- R2: The pin reaches the arbiter through two flip-flops. When the pin goes low before clock edge k, the external channel is enabled and nothing else is pending, the grant goes low after edge k+2.
- R3: The grant only asserts when the external channel has both its channel-enable bit and its request-enable bit set. If either bit is clear, a low pin starts no burst.
- R4: Once a burst starts, `burst_active`, `burst_ch` and the grant hold their values until `burst_done` is sampled high. The grant and `burst_active` deassert on the edge that samples `burst_done`.
- R5: One assertion of the pin yields exactly one burst. A pin held low after its burst completes starts no further burst until the pin has been seen high and then low again.
- R6: While the grant is low, the pin is not sampled: releasing and reasserting the pin during a burst does not count as a new request. After the pin is released and asserted again outside a burst, a new burst is granted.
- R7: Among pending channels, the lowest channel index wins. This holds unless the demotion of R8 applies.
- R8: If any other channel is pending on the edge that ends an external burst, the external channel is demoted. While demoted, it loses to every other pending channel, whatever the channel indices.
- R9: The demotion clears when a non-external channel starts a burst. After that, the external channel again competes by its index.
- R10: A one-cycle burst (`burst_done` already high when the burst starts) drives the grant low for exactly one cycle.
- R11: `burst_ch` gives the index of the channel that owns the current burst. Whenever the grant is low, `burst_ch` equals `ext_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | External DMA request pin, active low |
| ext_ch | input | CH_W | Index of the channel whose request source is the pin |
| ch_req | input | NUM_CH | Internal request per channel (ignored for the external channel) |
| ch_req_en | input | NUM_CH | Request-enable bit per channel |
| ch_en | input | NUM_CH | Channel-enable bit per channel |
| burst_done | input | 1 | Burst engine reports completion of the current burst |
| ext_grant_n | output | 1 | External grant pin, active low |
| burst_active | output | 1 | A burst is in progress |
| burst_ch | output | CH_W | Channel owning the current burst |

## Verification
The external channel is run alone to measure the pin-to-grant latency, and with each of its enable bits cleared to show that the grant depends on both. The pin is held low across and after a burst, and toggled during a burst, to separate "one burst per assertion" from level-triggered behaviour. Two internal channels are raised together to expose index priority. The external channel is then made to compete against a higher-index internal channel just after an external burst, and again after that channel has been served, to tell demotion apart from plain index order. A burst whose completion is already signalled at its start confirms the shortest grant.

// File: rtl/edr_pkg.sv
package edr_pkg;

    // Depth of the pin synchronizer chain
    localparam int unsigned EDR_SYNC_STAGES = 2;

    // Who owns the burst currently in flight
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_INT  = 2'd1,
        OWN_EXT  = 2'd2
    } owner_e;

endpackage

// File: rtl/edr_sync.sv
module edr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic hold,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (!hold) begin
            chain_d = {chain_q[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/edr_pick.sv
module edr_pick #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CH_W   = 3
) (
    input  logic [NUM_CH-1:0] pend,
    input  logic [CH_W-1:0]   ext_ch,
    input  logic              demote,
    output logic              win_vld,
    output logic [CH_W-1:0]   win_idx,
    output logic              others_any
);

    logic [NUM_CH-1:0] others;
    logic [NUM_CH-1:0] cand;

    always_comb begin
        others         = pend;
        others[ext_ch] = 1'b0;
        others_any     = |others;
        // A demoted external channel only wins when it is alone
        cand = (demote && others_any) ? others : pend;
        win_vld = |cand;
        win_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) win_idx = CH_W'(i);
        end
    end

endmodule

// File: rtl/ext_dma_req_arb.sv
module ext_dma_req_arb #(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req_n,
    input  logic [CH_W-1:0]   ext_ch,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_req_en,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              burst_done,
    output logic              ext_grant_n,
    output logic              burst_active,
    output logic [CH_W-1:0]   burst_ch
);

    import edr_pkg::*;

    typedef struct packed {
        owner_e          owner;
        logic [CH_W-1:0] ch;
        logic            armed;
        logic            demote;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              frozen;
    logic              sync_lvl;
    logic              ext_live;
    logic [NUM_CH-1:0] pend;
    logic              win_vld;
    logic [CH_W-1:0]   win_idx;
    logic              others_any;

    assign frozen = (ctl_q.owner == OWN_EXT);

    edr_sync #(
        .STAGES (EDR_SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (~ext_req_n),
        .hold  (frozen),
        .dout  (sync_lvl)
    );

    // A seen request counts only once: armed clears when its burst ends
    assign ext_live = sync_lvl & ctl_q.armed;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pend
        assign pend[g] = ch_en[g] & ch_req_en[g] &
                         ((ext_ch == CH_W'(g)) ? ext_live : ch_req[g]);
    end

    edr_pick #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_pick (
        .pend       (pend),
        .ext_ch     (ext_ch),
        .demote     (ctl_q.demote),
        .win_vld    (win_vld),
        .win_idx    (win_idx),
        .others_any (others_any)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!frozen && !sync_lvl) begin
            ctl_d.armed = 1'b1;
        end
        if (ctl_q.owner == OWN_NONE) begin
            if (win_vld) begin
                ctl_d.ch    = win_idx;
                ctl_d.owner = (win_idx == ext_ch) ? OWN_EXT : OWN_INT;
                if (win_idx != ext_ch) begin
                    ctl_d.demote = 1'b0;
                end
            end
        end else if (burst_done) begin
            ctl_d.owner = OWN_NONE;
            if (frozen) begin
                ctl_d.armed  = 1'b0;
                ctl_d.demote = others_any;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{owner: OWN_NONE, ch: '0, armed: 1'b1, demote: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ext_grant_n  = ~frozen;
    assign burst_active = (ctl_q.owner != OWN_NONE);
    assign burst_ch     = ctl_q.ch;

endmodule

// File: rtl/edr_checker.sv
module edr_checker #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_req_n,
    input logic [CH_W-1:0]   ext_ch,
    input logic [NUM_CH-1:0] ch_req_en,
    input logic [NUM_CH-1:0] ch_en,
    input logic              burst_done,
    input logic              ext_grant_n,
    input logic              burst_active,
    input logic [CH_W-1:0]   burst_ch
);

    AST_GRANT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) // R4
        !ext_grant_n |-> burst_active);

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R4
        (burst_active && !burst_done) |=> (burst_active && $stable(burst_ch) && $stable(ext_grant_n)));

    AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n) // R4
        (burst_active && burst_done) |=> (!burst_active && ext_grant_n));

    AST_GRANT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) // R3
        $fell(ext_grant_n) |-> $past(ch_en[ext_ch] && ch_req_en[ext_ch]));

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) // R2
        $fell(ext_grant_n) |-> $past(!ext_req_n, 3));

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n) // R5
        $rose(ext_grant_n) |=> ext_grant_n);

    AST_GRANT_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n) // R11
        !ext_grant_n |-> (burst_ch == ext_ch));

endmodule

bind ext_dma_req_arb edr_checker #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_req_n    (ext_req_n),
    .ext_ch       (ext_ch),
    .ch_req_en    (ch_req_en),
    .ch_en        (ch_en),
    .burst_done   (burst_done),
    .ext_grant_n  (ext_grant_n),
    .burst_active (burst_active),
    .burst_ch     (burst_ch)
);

// File: tb/ext_dma_req_arb_tb.sv
module ext_dma_req_arb_tb;

    localparam int NCH = 8;
    localparam int EXT = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ext_req_n = 1'b1;
    logic [2:0]     ext_ch = 3'(EXT);
    logic [NCH-1:0] ch_req = '0;
    logic [NCH-1:0] ch_req_en = '1;
    logic [NCH-1:0] ch_en = '1;
    logic           burst_done = 1'b0;
    logic           ext_grant_n;
    logic           burst_active;
    logic [2:0]     burst_ch;

    int    checks = 0;
    int    errs = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    ext_dma_req_arb u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req_n    (ext_req_n),
        .ext_ch       (ext_ch),
        .ch_req       (ch_req),
        .ch_req_en    (ch_req_en),
        .ch_en        (ch_en),
        .burst_done   (burst_done),
        .ext_grant_n  (ext_grant_n),
        .burst_active (burst_active),
        .burst_ch     (burst_ch)
    );

    // Behavioural reference: owner 0 idle, 1 internal burst, 2 pin burst
    int m_owner, m_ch, n_owner, n_ch, m_win;
    bit m_armed, m_demote, m_s1, m_s2;
    bit n_armed, n_demote, n_s1, n_s2, m_other, m_busy;
    bit m_pv [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_owner = 0; m_ch = 0; m_armed = 1; m_demote = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            n_owner = m_owner; n_ch = m_ch; n_armed = m_armed;
            n_demote = m_demote; n_s1 = m_s1; n_s2 = m_s2;
            m_busy = (m_owner == 2);
            m_other = 0;
            for (int i = 0; i < NCH; i++) begin
                m_pv[i] = ch_en[i] && ch_req_en[i] &&
                          ((i == EXT) ? (m_s2 && m_armed) : ch_req[i]);
                if (i != EXT && m_pv[i]) m_other = 1;
            end
            if (m_owner == 0) begin
                m_win = -1;
                for (int i = 0; i < NCH; i++)
                    if (m_pv[i] && m_win < 0 && !(i == EXT && m_demote && m_other)) m_win = i;
                if (m_win >= 0) begin
                    n_owner = (m_win == EXT) ? 2 : 1;
                    n_ch = m_win;
                    if (m_win != EXT) n_demote = 0;
                end
            end else if (burst_done) begin
                n_owner = 0;
                if (m_busy) begin
                    n_armed = 0;
                    n_demote = m_other;
                end
            end
            if (!m_busy) begin
                if (!m_s2) n_armed = 1;
                n_s1 = !ext_req_n;
                n_s2 = m_s1;
            end
            m_owner = n_owner; m_ch = n_ch; m_armed = n_armed;
            m_demote = n_demote; m_s1 = n_s1; m_s2 = n_s2;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(ext_grant_n == (m_owner != 2), {cur_req, " grant"}, int'(ext_grant_n), int'(m_owner != 2));
            chk(burst_active == (m_owner != 0), {cur_req, " active"}, int'(burst_active), int'(m_owner != 0));
            if (m_owner != 0)
                chk(int'(burst_ch) == m_ch, {cur_req, " channel"}, int'(burst_ch), m_ch);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_grant(string req);
        for (int i = 0; i < 40; i++) begin
            if (!ext_grant_n) return;
            @(negedge clk);
        end
        chk(0, {req, " grant timeout"}, 1, 0);
    endtask

    task automatic wait_active(string req);
        for (int i = 0; i < 40; i++) begin
            if (burst_active) return;
            @(negedge clk);
        end
        chk(0, {req, " burst timeout"}, 0, 1);
    endtask

    task automatic finish_burst();
        burst_done = 1'b1;
        step(1);
        burst_done = 1'b0;
    endtask

    task automatic watch(int n, output int falls, output int lows);
        bit prev;
        falls = 0; lows = 0;
        prev = ext_grant_n;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (prev && !ext_grant_n) falls++;
            if (!ext_grant_n) lows++;
            prev = ext_grant_n;
        end
    endtask

    initial begin
        int f, l;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(ext_grant_n == 1'b1, "R1 grant after reset", int'(ext_grant_n), 1);
        chk(burst_active == 1'b0, "R1 active after reset", int'(burst_active), 0);
        step(2);

        // R2 latency through two flops, R4 hold and release
        cur_req = "R2";
        ext_req_n = 1'b0;
        step(1); chk(ext_grant_n == 1'b1, "R2 grant edge1", int'(ext_grant_n), 1);
        step(1); chk(ext_grant_n == 1'b1, "R2 grant edge2", int'(ext_grant_n), 1);
        step(1); chk(ext_grant_n == 1'b0, "R2 grant edge3", int'(ext_grant_n), 0);
        chk(int'(burst_ch) == EXT, "R11 channel on grant", int'(burst_ch), EXT);
        ext_req_n = 1'b1;
        cur_req = "R4";
        step(2);
        chk(ext_grant_n == 1'b0, "R4 grant held", int'(ext_grant_n), 0);
        finish_burst();
        chk(ext_grant_n == 1'b1, "R4 grant released", int'(ext_grant_n), 1);
        chk(burst_active == 1'b0, "R4 active released", int'(burst_active), 0);
        step(6);

        // R3 enables gate the grant
        cur_req = "R3";
        ch_en[EXT] = 1'b0;
        ext_req_n = 1'b0;
        watch(10, f, l);
        chk(l == 0, "R3 channel disabled", l, 0);
        ch_en[EXT] = 1'b1;
        ch_req_en[EXT] = 1'b0;
        watch(10, f, l);
        chk(l == 0, "R3 request disabled", l, 0);
        ch_req_en[EXT] = 1'b1;
        wait_grant("R3");
        chk(ext_grant_n == 1'b0, "R3 grant once enabled", int'(ext_grant_n), 0);

        // R5 held request: one burst only
        cur_req = "R5";
        step(1);
        finish_burst();
        watch(15, f, l);
        chk(f == 0, "R5 no second burst while held", f, 0);
        ext_req_n = 1'b1;
        step(6);

        // R6 pin ignored during burst
        cur_req = "R6";
        ext_req_n = 1'b0;
        wait_grant("R6");
        ext_req_n = 1'b1;
        step(3);
        ext_req_n = 1'b0;
        step(2);
        finish_burst();
        watch(12, f, l);
        chk(f == 0, "R6 toggle during burst ignored", f, 0);
        ext_req_n = 1'b1;
        step(5);
        ext_req_n = 1'b0;
        wait_grant("R6");
        chk(ext_grant_n == 1'b0, "R6 fresh assertion granted", int'(ext_grant_n), 0);
        ext_req_n = 1'b1;
        finish_burst();
        step(6);

        // R7 index priority, R11 channel report
        cur_req = "R7";
        ch_req[5] = 1'b1;
        ch_req[1] = 1'b1;
        wait_active("R7");
        chk(int'(burst_ch) == 1, "R7 lowest index wins", int'(burst_ch), 1);
        chk(ext_grant_n == 1'b1, "R11 no grant for internal", int'(ext_grant_n), 1);
        step(1);
        ch_req[1] = 1'b0;
        finish_burst();
        wait_active("R7");
        chk(int'(burst_ch) == 5, "R11 next channel reported", int'(burst_ch), 5);
        ch_req[5] = 1'b0;
        finish_burst();
        step(3);

        // R8 demotion after external burst
        cur_req = "R8";
        ch_en[3] = 1'b0;
        ch_req[3] = 1'b1;
        ext_req_n = 1'b0;
        wait_grant("R8");
        ext_req_n = 1'b1;
        ch_en[3] = 1'b1;
        step(1);
        burst_done = 1'b1;
        step(1);
        burst_done = 1'b0;
        ch_en[3] = 1'b0;
        ch_req_en[EXT] = 1'b0;
        step(5);
        ext_req_n = 1'b0;
        step(3);
        ch_req_en[EXT] = 1'b1;
        ch_en[3] = 1'b1;
        step(1);
        chk(int'(burst_ch) == 3, "R8 demoted external loses", int'(burst_ch), 3);
        chk(ext_grant_n == 1'b1, "R8 no grant while demoted", int'(ext_grant_n), 1);

        // R9 demotion cleared after another channel served
        cur_req = "R9";
        finish_burst();
        wait_active("R9");
        chk(int'(burst_ch) == EXT, "R9 external wins by index", int'(burst_ch), EXT);
        chk(ext_grant_n == 1'b0, "R9 grant asserted", int'(ext_grant_n), 0);
        ext_req_n = 1'b1;
        ch_req[3] = 1'b0;
        finish_burst();
        step(6);

        // R10 one-cycle burst
        cur_req = "R10";
        burst_done = 1'b1;
        ext_req_n = 1'b0;
        watch(8, f, l);
        chk(l == 1, "R10 grant low cycles", l, 1);
        chk(f == 1, "R10 single grant", f, 1);
        burst_done = 1'b0;
        ext_req_n = 1'b1;
        step(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule